// File: doc/BRIEF.md
# Three-Slot Receive Message Queue

This block sits behind the acceptance filter of a CAN-style receiver. Each frame the filter accepts arrives as a one-cycle strobe with its identifier, its length code and up to eight data bytes. The block stores up to three such frames in arrival order. Software sees only the oldest stored frame through a small register port. It frees that frame by writing a release bit, and the hardware then clears that bit again.

A control/status word reports how many frames are pending. It also holds a sticky full flag and a sticky overflow flag, and software clears each of them by writing 1. A frame that arrives while all three slots are occupied, with no release freeing one in the same cycle, is discarded and recorded in the overflow flag. A single interrupt line is high while either flag is set together with its enable bit.

Top module: `rx_msg_queue`

## Requirements
- R1: Bits [1:0] of the control word (address 0) give the number of pending frames, 0 to 3. The value never exceeds 3 and is 0 after reset.
- R2: An accepted frame that arrives while fewer than three frames are pending is stored behind the others, and the count rises by one at that clock edge.
- R3: Writing 1 to bit 8 of address 0 while frames are pending sets the release bit, which reads as 1 on the next cycle. At the following edge the oldest frame is freed, the count drops by one and bit 8 reads 0 again.
- R4: Writing the release bit while no frame is pending has no effect: bit 8 stays 0 and the count stays 0.
- R5: The full flag (bit 4 of address 0) is set when a stored frame brings the count from 2 to 3. Writing 1 to bit 4 clears it, and writing 0 leaves it unchanged.
- R6: The overflow flag (bit 5 of address 0) is set when a frame arrives while three are pending and no release frees a slot in that cycle. That frame is discarded and the stored frames are not changed. Writing 1 to bit 5 clears the flag.
- R7: The interrupt output equals (full flag AND enable bit 0 of address 1) OR (overflow flag AND enable bit 1 of address 1).
- R8: Only the oldest frame is readable: the identifier at address 2 (bits [28:0]), the length code at address 3 (bits [3:0]), data bytes 0 to 3 at address 4 and bytes 4 to 7 at address 5. All of these read 0 while the queue is empty, and the next frame appears only after a release.
- R9: When a frame arrives in the same cycle as a release takes effect, the count is unchanged, the head advances and the new frame is stored. This also holds at a count of 3, where neither the overflow flag nor the full flag is set.
- R10: Reserved bits and unmapped addresses (6, 7) read 0 and ignore writes. Reset clears the count, both flags, the release bit and both enables.
- R11: If a flag is set by hardware in the same cycle that software writes 1 to clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | One-cycle strobe: a frame passed the filter |
| acc_id | input | 29 | Identifier of the accepted frame |
| acc_dlc | input | 4 | Length code of the accepted frame |
| acc_data | input | 64 | Data bytes, byte 0 in bits [7:0] |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the cycle in which a release and an arrival coincide. A design that treated that cycle as a push into a full queue would raise overflow and lose the frame, and one that ignored the push would shrink the count. It also checks a clear write that lands in the same cycle as a new overflow, where a design giving the clear priority would drop the event. Further checks cover release writes to an empty queue, which must not underflow the count or leave the release bit stuck at 1, and an overflow arrival, which must not overwrite the oldest or newest slot. Randomised traffic is compared on every clock against a queue-based model, which exposes slips of one cycle in when the release takes effect and when the flags change.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  // register word addresses
  localparam int ADDR_CTL   = 0;
  localparam int ADDR_IEN   = 1;
  localparam int ADDR_ID    = 2;
  localparam int ADDR_DLC   = 3;
  localparam int ADDR_DATA0 = 4;

  // control word bit positions
  localparam int CTL_CNT_LSB  = 0;
  localparam int CTL_FULL_BIT = 4;
  localparam int CTL_OVF_BIT  = 5;
  localparam int CTL_REL_BIT  = 8;

  // enable word bit positions
  localparam int IEN_FULL_BIT = 0;
  localparam int IEN_OVF_BIT  = 1;
  localparam int IEN_W        = 2;

  // circular slot index advance
  function automatic logic [31:0] ptr_step(input logic [31:0] p, input logic [31:0] depth);
    return (p + 32'd1 == depth) ? 32'd0 : p + 32'd1;
  endfunction

  // occupancy after one cycle of push/pop activity
  function automatic logic [31:0] occ_next(input logic [31:0] occ, input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return occ + 32'd1;
      2'b01:   return occ - 32'd1;
      default: return occ;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned PTR_W  = 2,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DLC_W-1:0]  in_dlc,
  input  logic [DATA_W-1:0] in_data,
  output logic [ID_W-1:0]   head_id,
  output logic [DLC_W-1:0]  head_dlc,
  output logic [DATA_W-1:0] head_data
);

  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [DLC_W-1:0]  dlc_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  slot_sel;

  // one-hot slot write select
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      slot_sel[s] = wr_en && (wr_ptr == PTR_W'(s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        id_q[s]   <= '0;
        dlc_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (slot_sel[s]) begin
          id_q[s]   <= in_id;
          dlc_q[s]  <= in_dlc;
          data_q[s] <= in_data;
        end
      end
    end
  end

  always_comb begin
    head_id   = id_q[rd_ptr];
    head_dlc  = dlc_q[rd_ptr];
    head_data = data_q[rd_ptr];
  end

endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             clr_full,
  input  logic             clr_ovf,
  input  logic             set_rel,
  output logic [CNT_W-1:0] occ,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full_flag,
  output logic             ovf_flag,
  output logic             rel_pend,
  output logic             push,
  output logic             pop,
  output logic             drop
);
  import rxq_pkg::*;

  localparam logic [CNT_W-1:0] OCC_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] OCC_PRE = CNT_W'(DEPTH - 1);

  logic at_max;
  logic full_set;
  logic rel_take;

  always_comb begin
    at_max   = (occ == OCC_MAX);
    pop      = rel_pend && (occ != '0);
    push     = acc_vld && (!at_max || pop);
    drop     = acc_vld && at_max && !pop;
    full_set = push && !pop && (occ == OCC_PRE);
    rel_take = set_rel && (occ != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      occ <= CNT_W'(occ_next(32'(occ), push, pop));
      if (push) wr_ptr <= PTR_W'(ptr_step(32'(wr_ptr), 32'(DEPTH)));
      if (pop)  rd_ptr <= PTR_W'(ptr_step(32'(rd_ptr), 32'(DEPTH)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pend <= 1'b0;
    end else if (pop) begin
      rel_pend <= 1'b0;
    end else if (rel_take) begin
      rel_pend <= 1'b1;
    end
  end

  // hardware set takes priority over software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (full_set)      full_flag <= 1'b1;
      else if (clr_full) full_flag <= 1'b0;
      if (drop)          ovf_flag  <= 1'b1;
      else if (clr_ovf)  ovf_flag  <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_regs.sv
`timescale 1ns/1ps
module rxq_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  occ,
  input  logic              full_flag,
  input  logic              ovf_flag,
  input  logic              rel_pend,
  input  logic [ID_W-1:0]   head_id,
  input  logic [DLC_W-1:0]  head_dlc,
  input  logic [DATA_W-1:0] head_data,
  output logic              clr_full,
  output logic              clr_ovf,
  output logic              set_rel,
  output logic [IEN_W-1:0]  ien,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  import rxq_pkg::*;

  localparam int unsigned DATA_WORDS = DATA_W / REG_W;

  logic ctl_wr;
  logic ien_wr;
  logic has_head;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    ctl_wr   = reg_wr && (reg_addr == ADDR_W'(ADDR_CTL));
    ien_wr   = reg_wr && (reg_addr == ADDR_W'(ADDR_IEN));
    clr_full = ctl_wr && reg_wdata[CTL_FULL_BIT];
    clr_ovf  = ctl_wr && reg_wdata[CTL_OVF_BIT];
    set_rel  = ctl_wr && reg_wdata[CTL_REL_BIT];
    has_head = (occ != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
    end else if (ien_wr) begin
      ien <= reg_wdata[IEN_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTL)) begin
      reg_rdata[CTL_CNT_LSB +: CNT_W] = occ;
      reg_rdata[CTL_FULL_BIT]          = full_flag;
      reg_rdata[CTL_OVF_BIT]           = ovf_flag;
      reg_rdata[CTL_REL_BIT]           = rel_pend;
    end else if (reg_addr == ADDR_W'(ADDR_IEN)) begin
      reg_rdata[IEN_W-1:0] = ien;
    end else if (reg_addr == ADDR_W'(ADDR_ID)) begin
      if (has_head) reg_rdata[ID_W-1:0] = head_id;
    end else if (reg_addr == ADDR_W'(ADDR_DLC)) begin
      if (has_head) reg_rdata[DLC_W-1:0] = head_dlc;
    end
    for (int w = 0; w < DATA_WORDS; w++) begin
      if (has_head && reg_addr == ADDR_W'(ADDR_DATA0 + w)) begin
        reg_rdata = head_data[w*REG_W +: REG_W];
      end
    end
  end

  assign irq = (full_flag && ien[IEN_FULL_BIT]) || (ovf_flag && ien[IEN_OVF_BIT]);

endmodule

// File: rtl/rx_msg_queue.sv
`timescale 1ns/1ps
module rx_msg_queue #(
  parameter int unsigned DEPTH      = 3,
  parameter int unsigned ID_W       = 29,
  parameter int unsigned DLC_W      = 4,
  parameter int unsigned DATA_BYTES = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned REG_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_vld,
  input  logic [ID_W-1:0]         acc_id,
  input  logic [DLC_W-1:0]        acc_dlc,
  input  logic [DATA_BYTES*8-1:0] acc_data,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    irq
);
  import rxq_pkg::*;

  localparam int unsigned DATA_W = DATA_BYTES * 8;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // internal events brought out for the checker
  logic [CNT_W-1:0]  occ;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              full_flag;
  logic              ovf_flag;
  logic              rel_pend;
  logic              push;
  logic              pop;
  logic              drop;
  logic              clr_full;
  logic              clr_ovf;
  logic              set_rel;
  logic [IEN_W-1:0]  ien;
  logic [ID_W-1:0]   head_id;
  logic [DLC_W-1:0]  head_dlc;
  logic [DATA_W-1:0] head_data;

  rxq_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .clr_full  (clr_full),
    .clr_ovf   (clr_ovf),
    .set_rel   (set_rel),
    .occ       (occ),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .full_flag (full_flag),
    .ovf_flag  (ovf_flag),
    .rel_pend  (rel_pend),
    .push      (push),
    .pop       (pop),
    .drop      (drop)
  );

  rxq_store #(
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W),
    .ID_W   (ID_W),
    .DLC_W  (DLC_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .in_id     (acc_id),
    .in_dlc    (acc_dlc),
    .in_data   (acc_data),
    .head_id   (head_id),
    .head_dlc  (head_dlc),
    .head_data (head_data)
  );

  rxq_regs #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .CNT_W  (CNT_W),
    .ID_W   (ID_W),
    .DLC_W  (DLC_W),
    .DATA_W (DATA_W),
    .IEN_W  (IEN_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .occ       (occ),
    .full_flag (full_flag),
    .ovf_flag  (ovf_flag),
    .rel_pend  (rel_pend),
    .head_id   (head_id),
    .head_dlc  (head_dlc),
    .head_data (head_data),
    .clr_full  (clr_full),
    .clr_ovf   (clr_ovf),
    .set_rel   (set_rel),
    .ien       (ien),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

endmodule

// File: rtl/rxq_chk.sv
`timescale 1ns/1ps
module rxq_chk #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned IEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] occ,
  input logic             push,
  input logic             pop,
  input logic             drop,
  input logic             full_flag,
  input logic             ovf_flag,
  input logic             rel_pend,
  input logic [IEN_W-1:0] ien,
  input logic             irq
);

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> occ == $past(occ) + CNT_W'(1));

  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> occ == $past(occ) - CNT_W'(1));

  // R3
  rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !rel_pend);

  // R4
  empty_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !pop);

  // R5
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && occ == CNT_W'(DEPTH - 1)) |=> full_flag);

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> occ == CNT_W'(DEPTH));

  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag);

  // R9
  swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> occ == $past(occ));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_flag && !ovf_flag) |-> !irq);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

endmodule

bind rx_msg_queue rxq_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .IEN_W (rxq_pkg::IEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .occ       (occ),
  .push      (push),
  .pop       (pop),
  .drop      (drop),
  .full_flag (full_flag),
  .ovf_flag  (ovf_flag),
  .rel_pend  (rel_pend),
  .ien       (ien),
  .irq       (irq)
);

// File: tb/rx_msg_queue_tb.sv
`timescale 1ns/1ps
module rx_msg_queue_tb;

  localparam real HALF = 2.5;

  typedef struct packed {
    logic [28:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic [28:0] acc_id = '0;
  logic [3:0]  acc_dlc = '0;
  logic [63:0] acc_data = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] last_rd;

  // behavioural reference state
  frame_t     mq[$];
  bit         m_pend, m_full, m_ovf;
  logic [1:0] m_ien;

  localparam frame_t NOFR = '0;

  always #(HALF) clk = ~clk;

  rx_msg_queue u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .acc_id    (acc_id),
    .acc_dlc   (acc_dlc),
    .acc_data  (acc_data),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic frame_t mkf(input int n);
    frame_t f;
    f.id   = 29'(32'h0ABC_0000 + n);
    f.dlc  = 4'(n);
    f.data = {32'hC0DE_0000 + 32'(n), 32'h0000_BEEF + 32'(n * 256)};
    return f;
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd0:                return "R1";
      3'd1:                return "R7";
      3'd2, 3'd3, 3'd4, 3'd5: return "R8";
      default:             return "R10";
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      3'd0: r = {23'b0, m_pend, 2'b0, m_ovf, m_full, 2'b0, 2'(mq.size())};
      3'd1: r = {30'b0, m_ien};
      3'd2: if (mq.size() > 0) r = {3'b0, mq[0].id};
      3'd3: if (mq.size() > 0) r = {28'b0, mq[0].dlc};
      3'd4: if (mq.size() > 0) r = mq[0].data[31:0];
      3'd5: if (mq.size() > 0) r = mq[0].data[63:32];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic m_irq();
    return (m_full && m_ien[0]) || (m_ovf && m_ien[1]);
  endfunction

  task automatic m_reset();
    mq.delete();
    m_pend = 0; m_full = 0; m_ovf = 0; m_ien = '0;
  endtask

  task automatic m_update(input logic av, input frame_t f, input logic wr,
                          input logic [2:0] a, input logic [31:0] wd);
    int pre;
    bit pp, fset, oset, cw;
    pre  = mq.size();
    pp   = m_pend && (pre > 0);
    fset = 0;
    oset = 0;
    cw   = wr && (a == 3'd0);
    if (pp) void'(mq.pop_front());
    if (av) begin
      if (pre < 3 || pp) begin
        mq.push_back(f);
        if (!pp && pre == 2) fset = 1;
      end else begin
        oset = 1;
      end
    end
    if (pp) m_pend = 0;
    else if (cw && wd[8] && pre > 0) m_pend = 1;
    if (fset) m_full = 1;
    else if (cw && wd[4]) m_full = 0;
    if (oset) m_ovf = 1;
    else if (cw && wd[5]) m_ovf = 0;
    if (wr && a == 3'd1) m_ien = wd[1:0];
  endtask

  // one clock: drive, compare combinational outputs, advance model
  task automatic step(input logic av, input frame_t f, input logic wr,
                      input logic [2:0] a, input logic [31:0] wd);
    acc_vld   = av;
    acc_id    = f.id;
    acc_dlc   = f.dlc;
    acc_data  = f.data;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = wd;
    #1;
    last_rd = reg_rdata;
    chk(tag_for(a), reg_rdata, m_read(a));
    chk("R7", {31'b0, irq}, {31'b0, m_irq()});
    @(posedge clk);
    m_update(av, f, wr, a, wd);
    @(negedge clk);
  endtask

  task automatic push_f(input frame_t f);
    step(1'b1, f, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] wd);
    step(1'b0, NOFR, 1'b1, a, wd);
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input logic [31:0] exp);
    step(1'b0, NOFR, 1'b0, a, 32'h0);
    chk(tag, last_rd, exp);
  endtask

  task automatic do_reset();
    acc_vld = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();

    // R10 reset state
    peek(3'd0, "R10", 32'h0);
    peek(3'd1, "R10", 32'h0);

    // R4 release on empty queue
    wr_reg(3'd0, 32'h100);
    peek(3'd0, "R4", 32'h0);

    // R2 / R8 first frame
    push_f(mkf(1));
    peek(3'd0, "R2", 32'h1);
    peek(3'd2, "R8", {3'b0, mkf(1).id});
    peek(3'd3, "R8", {28'b0, mkf(1).dlc});
    peek(3'd5, "R8", mkf(1).data[63:32]);

    // R5 full on third frame
    push_f(mkf(2));
    push_f(mkf(3));
    peek(3'd0, "R5", 32'h13);

    // R7 overflow enable only: full alone keeps irq low
    wr_reg(3'd1, 32'h2);
    chk("R7", {31'b0, irq}, 32'h0);

    // R6 overflow drops the frame
    push_f(mkf(4));
    peek(3'd0, "R6", 32'h33);
    chk("R7", {31'b0, irq}, 32'h1);
    peek(3'd2, "R6", {3'b0, mkf(1).id});

    // R11 set beats clear
    step(1'b1, mkf(5), 1'b1, 3'd0, 32'h20);
    peek(3'd0, "R11", 32'h33);

    // R5 / R6 write-1 clear
    wr_reg(3'd0, 32'h30);
    peek(3'd0, "R5", 32'h3);
    chk("R7", {31'b0, irq}, 32'h0);

    // R3 release timing
    wr_reg(3'd0, 32'h100);
    peek(3'd0, "R3", 32'h103);
    peek(3'd0, "R3", 32'h2);
    peek(3'd2, "R8", {3'b0, mkf(2).id});
    peek(3'd4, "R6", mkf(2).data[31:0]);

    // R9 arrival coincides with release
    wr_reg(3'd0, 32'h100);
    push_f(mkf(6));
    peek(3'd0, "R9", 32'h2);
    peek(3'd2, "R9", {3'b0, mkf(3).id});

    // R9 at three pending: no overflow, no full
    push_f(mkf(7));
    wr_reg(3'd0, 32'h10);
    wr_reg(3'd0, 32'h100);
    push_f(mkf(8));
    peek(3'd0, "R9", 32'h3);
    peek(3'd2, "R9", {3'b0, mkf(6).id});

    // R10 reserved bits and addresses
    wr_reg(3'd7, 32'hFFFF_FFFF);
    peek(3'd7, "R10", 32'h0);
    wr_reg(3'd0, 32'hFFFF_FE0F);
    peek(3'd0, "R10", 32'h3);
    wr_reg(3'd1, 32'hFFFF_FFFC);
    peek(3'd1, "R10", 32'h0);

    // R8 drain to empty: head reads zero
    for (int k = 0; k < 3; k++) begin
      wr_reg(3'd0, 32'h100);
      step(1'b0, NOFR, 1'b0, 3'd0, 32'h0);
    end
    peek(3'd0, "R8", 32'h0);
    peek(3'd2, "R8", 32'h0);
    peek(3'd4, "R8", 32'h0);

    // randomised traffic against the model
    for (int k = 0; k < 3000; k++) begin
      frame_t f;
      f.id   = 29'($urandom);
      f.dlc  = 4'($urandom);
      f.data = {$urandom, $urandom};
      step(($urandom % 3) == 0, f, ($urandom % 4) == 0, 3'($urandom), $urandom);
    end

    // R10 reset clears everything after activity
    push_f(mkf(9));
    wr_reg(3'd1, 32'h3);
    do_reset();
    peek(3'd0, "R10", 32'h0);
    peek(3'd1, "R10", 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule